// File: doc/BRIEF.md
# Block Error Counter Pair

This block keeps two independent 8-bit tallies of block errors. One tallies errors reported by the far end of a link. The other tallies errors detected locally. Each tally advances by one on every single-cycle error pulse presented to it. Each has its own clear strobe, so a register interface can read a count and then zero it. The block does not detect CRC mismatches and does not decode far-end error bits. It only counts the pulses it is given.

A run-time mode input sets what happens when a tally is already at 0xFF and another pulse arrives. In saturating mode the count stays at 0xFF. In wrapping mode the count goes back to 0x00. The mode is examined only in a cycle where a full tally receives a pulse, so changing it on its own never disturbs a stored count. The configuration register that drives the mode input resets it to 0, which makes saturation the default. Error pulses and clears are plain strobes that are sampled on every rising clock edge. There is no handshake, and a pulse is never stalled or dropped.

Top module: `blkerr_pair`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets both counts to 0x00.
- R2: An error pulse with no clear, on a count below 0xFF, raises that count by exactly one at the next edge.
- R3: With `rollover_en` = 0, an error pulse on a count of 0xFF leaves it at 0xFF.
- R4: With `rollover_en` = 1, an error pulse on a count of 0xFF sets it to 0x00.
- R5: A clear strobe without an error pulse sets that count to 0x00 at the next edge.
- R6: A clear strobe and an error pulse on the same counter in the same cycle leave that count at 0x01.
- R7: The two counters are independent. Both may advance in the same cycle, and a pulse or clear on one counter never changes the other.
- R8: Changing `rollover_en` without an error pulse leaves both counts unchanged. A new mode value takes effect at the next pulse on a full count.
- R9: With neither an error pulse nor a clear, a count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| rollover_en | input | 1 | 0: saturate at 0xFF; 1: wrap 0xFF to 0x00 |
| fe_err | input | 1 | Far-end block error pulse |
| fe_clr | input | 1 | Far-end count clear strobe |
| ne_err | input | 1 | Near-end block error pulse |
| ne_clr | input | 1 | Near-end count clear strobe |
| fe_count | output | 8 | Far-end error count |
| ne_count | output | 8 | Near-end error count |

## Verification
The bench drives each counter to 0xFF and then applies one more pulse in both modes. A design that confused the two modes, or that compared against the wrong full-scale value, would stop early or wrap in saturating mode. It flips the mode while a count sits at 0xFF with no pulse present, which exposes a design that reacts to the mode bit on its own. It applies a clear and an error pulse together, where a design that gave priority to either strobe would read 0 or the old count plus one instead of 1. It also drives mixed pulses and clears across both lanes, which shows any leakage between the counters.

// File: rtl/blkerr_pkg.sv
package blkerr_pkg;

  // Behaviour of a tally that receives a pulse while at full scale
  typedef enum logic {
    FULL_HOLD = 1'b0,
    FULL_WRAP = 1'b1
  } full_policy_e;

  // Lane indices inside the pair
  localparam int unsigned LANE_FAR  = 0;
  localparam int unsigned LANE_NEAR = 1;
  localparam int unsigned LANE_CNT  = 2;

endpackage

// File: rtl/blkerr_step.sv
// Next-value logic for one error tally.
module blkerr_step
  import blkerr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             hit,
  input  logic             zap,
  input  full_policy_e     policy,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};
  localparam logic [WIDTH-1:0] FULL = '1;

  logic at_full;
  assign at_full = (cur == FULL);

  always_comb begin
    nxt = cur;
    if (zap) begin
      // a pulse arriving alongside the clear is the first of the new tally
      nxt = hit ? ONE : ZERO;
    end else if (hit) begin
      if (!at_full) begin
        nxt = cur + ONE;
      end else if (policy == FULL_WRAP) begin
        nxt = ZERO;
      end else begin
        nxt = FULL;
      end
    end
  end

endmodule

// File: rtl/blkerr_lane.sv
// One registered error tally.
module blkerr_lane
  import blkerr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit,
  input  logic             zap,
  input  full_policy_e     policy,
  output logic [WIDTH-1:0] count
);

  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_d;

  blkerr_step #(.WIDTH(WIDTH)) u_step (
    .cur    (count_q),
    .hit    (hit),
    .zap    (zap),
    .policy (policy),
    .nxt    (count_d)
  );

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= count_d;
  end

  assign count = count_q;

endmodule

// File: rtl/blkerr_pair.sv
// Far-end / near-end block error counter pair.
module blkerr_pair
  import blkerr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rollover_en,
  input  logic             fe_err,
  input  logic             fe_clr,
  input  logic             ne_err,
  input  logic             ne_clr,
  output logic [WIDTH-1:0] fe_count,
  output logic [WIDTH-1:0] ne_count
);

  full_policy_e            policy;
  logic [LANE_CNT-1:0]     hit_v;
  logic [LANE_CNT-1:0]     zap_v;
  logic [WIDTH-1:0]        cnt_v [LANE_CNT];

  assign policy = rollover_en ? FULL_WRAP : FULL_HOLD;

  assign hit_v[LANE_FAR]  = fe_err;
  assign hit_v[LANE_NEAR] = ne_err;
  assign zap_v[LANE_FAR]  = fe_clr;
  assign zap_v[LANE_NEAR] = ne_clr;

  for (genvar g = 0; g < LANE_CNT; g++) begin : g_lane
    blkerr_lane #(.WIDTH(WIDTH)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .hit    (hit_v[g]),
      .zap    (zap_v[g]),
      .policy (policy),
      .count  (cnt_v[g])
    );
  end

  assign fe_count = cnt_v[LANE_FAR];
  assign ne_count = cnt_v[LANE_NEAR];

endmodule

// File: rtl/blkerr_pair_chk.sv
module blkerr_pair_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             rollover_en,
  input logic             fe_err,
  input logic             fe_clr,
  input logic             ne_err,
  input logic             ne_clr,
  input logic [WIDTH-1:0] fe_count,
  input logic [WIDTH-1:0] ne_count
);

  localparam logic [WIDTH-1:0] FULL = '1;
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (fe_count == '0) && (ne_count == '0)); // R1

  AST_FE_STEP: assert property (@(posedge clk) disable iff (rst)
    fe_err && !fe_clr && (fe_count != FULL) |=> fe_count == $past(fe_count) + ONE); // R2
  AST_NE_STEP: assert property (@(posedge clk) disable iff (rst)
    ne_err && !ne_clr && (ne_count != FULL) |=> ne_count == $past(ne_count) + ONE); // R2

  AST_FE_PIN_FULL: assert property (@(posedge clk) disable iff (rst)
    !rollover_en && fe_err && !fe_clr && (fe_count == FULL) |=> fe_count == FULL); // R3
  AST_NE_PIN_FULL: assert property (@(posedge clk) disable iff (rst)
    !rollover_en && ne_err && !ne_clr && (ne_count == FULL) |=> ne_count == FULL); // R3

  AST_FE_WRAP: assert property (@(posedge clk) disable iff (rst)
    rollover_en && fe_err && !fe_clr && (fe_count == FULL) |=> fe_count == '0); // R4
  AST_NE_WRAP: assert property (@(posedge clk) disable iff (rst)
    rollover_en && ne_err && !ne_clr && (ne_count == FULL) |=> ne_count == '0); // R4

  AST_FE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    fe_clr && !fe_err |=> fe_count == '0); // R5
  AST_NE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ne_clr && !ne_err |=> ne_count == '0); // R5

  AST_FE_CLEAR_AND_HIT: assert property (@(posedge clk) disable iff (rst)
    fe_clr && fe_err |=> fe_count == ONE); // R6
  AST_NE_CLEAR_AND_HIT: assert property (@(posedge clk) disable iff (rst)
    ne_clr && ne_err |=> ne_count == ONE); // R6

  AST_FE_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !fe_err && !fe_clr |=> $stable(fe_count)); // R9
  AST_NE_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !ne_err && !ne_clr |=> $stable(ne_count)); // R9

endmodule

bind blkerr_pair blkerr_pair_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rollover_en (rollover_en),
  .fe_err      (fe_err),
  .fe_clr      (fe_clr),
  .ne_err      (ne_err),
  .ne_clr      (ne_clr),
  .fe_count    (fe_count),
  .ne_count    (ne_count)
);

// File: tb/blkerr_pair_test.sv
`timescale 1ns/1ps
module blkerr_pair_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rollover_en = 1'b0;
  logic       fe_err = 1'b0, fe_clr = 1'b0, ne_err = 1'b0, ne_clr = 1'b0;
  logic [7:0] fe_count, ne_count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  blkerr_pair uut (
    .clk(clk), .rst(rst), .rollover_en(rollover_en),
    .fe_err(fe_err), .fe_clr(fe_clr), .ne_err(ne_err), .ne_clr(ne_clr),
    .fe_count(fe_count), .ne_count(ne_count)
  );

  // {mode, fe_err, fe_clr, ne_err, ne_clr, expected fe, expected ne}
  localparam int NVEC = 10;
  localparam logic [20:0] VEC [NVEC] = '{
    {5'b01000, 8'd1, 8'd0},   // R2 far advances
    {5'b01010, 8'd2, 8'd1},   // R7 both advance together
    {5'b00010, 8'd2, 8'd2},   // R7 near only
    {5'b00000, 8'd2, 8'd2},   // R9 idle hold
    {5'b10000, 8'd2, 8'd2},   // R8 mode flip alone
    {5'b01100, 8'd1, 8'd2},   // R6 clear with pulse
    {5'b00110, 8'd0, 8'd3},   // R5 clear far, near advances
    {5'b00001, 8'd0, 8'd0},   // R5 clear near
    {5'b01011, 8'd1, 8'd1},   // R6 near clear with pulse
    {5'b11010, 8'd2, 8'd2}    // R2 in wrap mode below full
  };

  task automatic drive(input logic m, input logic fe, input logic fc,
                       input logic ne, input logic nc);
    rollover_en = m; fe_err = fe; fe_clr = fc; ne_err = ne; ne_clr = nc;
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%02h expected 0x%02h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    check("R1", "fe after reset", fe_count, 8'h00);
    check("R1", "ne after reset", ne_count, 8'h00);
    rst = 1'b0;

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16]);
      check("R2-table", $sformatf("vec %0d fe", i), fe_count, VEC[i][15:8]);
      check("R7-table", $sformatf("vec %0d ne", i), ne_count, VEC[i][7:0]);
    end

    // pump far tally from 2 to full (253 pulses), near idle at 2
    for (int i = 0; i < 253; i++) drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R2", "fe reaches full", fe_count, 8'hFF);
    check("R7", "ne untouched by far pulses", ne_count, 8'h02);
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R3", "fe pinned at full", fe_count, 8'hFF);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8", "fe after mode flip only", fe_count, 8'hFF);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8", "fe after mode flip back", fe_count, 8'hFF);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R4", "fe wraps", fe_count, 8'h00);
    check("R7", "ne unchanged by far wrap", ne_count, 8'h02);

    // pump near tally to full in wrap mode and wrap it
    for (int i = 0; i < 253; i++) drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R2", "ne reaches full", ne_count, 8'hFF);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R3", "ne pinned at full", ne_count, 8'hFF);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R4", "ne wraps", ne_count, 8'h00);
    check("R7", "fe advances alongside", fe_count, 8'h01);
    drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
    check("R6", "fe clear with pulse", fe_count, 8'h01);

    // reset mid-run
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    rst = 1'b1;
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R1", "fe after mid-run reset", fe_count, 8'h00);
    check("R1", "ne after mid-run reset", ne_count, 8'h00);
    rst = 1'b0;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R9", "fe idle after reset", fe_count, 8'h00);

    finish_run();
  end

endmodule